// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a Serial Wire Debug link. It carries out one register access at a time, aimed at either the debug port or an access port of the target. It generates the serial clock from the system clock and drives or releases the bidirectional data line. For each access it sends an 8-bit request header and reads back a 3-bit acknowledge. It then moves a 32-bit word plus one parity bit, in whichever direction the access needs.

A WAIT acknowledge makes the engine resend the request on its own, up to a fixed number of attempts. A FAULT acknowledge sets a sticky flag. While that flag is set, access-port requests are refused and nothing is sent on the wire. Debug-port requests still go out, so software can read the error state and write the abort register. Software then pulses a clear input to drop the flag.

Requests arrive on a valid/ready port. `req_ready` is high only while the engine is idle. The requester holds `req_valid` and the request fields steady until a cycle in which both `req_valid` and `req_ready` are high, and the fields are taken in that cycle. Results come back with a one-cycle `done` pulse.

Top module: `swd_xact_engine`

## Requirements
- R1: `req_ready` is 1 exactly when `busy` is 0. A request is taken on a clock where `req_valid` and `req_ready` are both 1. `done` is a single-cycle pulse. `rsp_status` and `rsp_rdata` keep their values from `done` until the next request is taken.
- R2: The request header is sent as 8 line bits, in order from bit 0 to bit 7:
  - bit 0: 1
  - bit 1: `req_ap`
  - bit 2: `req_rnw`
  - bit 3: `req_addr[0]`
  - bit 4: `req_addr[1]`
  - bit 5: the XOR of bits 1 to 4
  - bit 6: 0
  - bit 7: 1
- R3: `swclk` is low while idle. Each bit slot lasts 2*HALF_DIV clocks and starts with `swclk` low. The engine changes `swdio_out`/`swdio_oe` only when `swclk` falls or at the start of a slot, and samples `swdio_in` in the cycle where `swclk` rises.
- R4: `swdio_oe` is 0 in the following slots:
  - one turnaround slot after the header;
  - the 3 acknowledge slots;
  - the 32 read data slots and the read parity slot;
  - one turnaround slot after the read parity bit;
  - one turnaround slot after any acknowledge other than OK-on-read, which includes the slot before write data.
- R5: The acknowledge is taken first-received bit as bit 0. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. Any other value ends the access with status PROTO (3). Status codes: OK=0, FAULT=1, TIMEOUT=2, PROTO=3, PARITY=4, REFUSED=5.
- R6: After a WAIT the engine spends one turnaround slot and then resends the same header. If the WAIT comes on attempt number MAX_TRIES, the access ends with status TIMEOUT after the turnaround slot.
- R7: A FAULT acknowledge sets `sticky_fault` and ends the access with status FAULT and `rsp_rdata`=0.
- R8: While `sticky_fault` is 1, an access-port request (`req_ap`=1) produces no `swclk` edge. `done` follows on the next clock with status REFUSED. Debug-port requests still run normally.
- R9: Only `fault_clr` clears `sticky_fault`. If a FAULT arrives in the same cycle as `fault_clr`, setting wins.
- R10: A read with OK collects 32 data bits, least significant first, then one parity bit. Status is OK when that bit equals the XOR of the data and PARITY (4) otherwise. In both cases `rsp_rdata` returns the collected word.
- R11: A write with OK drives `req_wdata` least significant bit first, then its XOR, then two slots with the line driven low, and only then pulses `done`.
- R12: `rsp_rdata` is 0 after any write and after a FAULT, TIMEOUT, PROTO or REFUSED result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ap | input | 1 | 1 selects an access port, 0 the debug port |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits A[3:2] |
| req_wdata | input | 32 | Write word |
| fault_clr | input | 1 | Clears the sticky fault flag |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 3 | Result code (see R5) |
| rsp_rdata | output | 32 | Read word |
| sticky_fault | output | 1 | FAULT seen and not yet cleared |
| swclk | output | 1 | Serial clock to target |
| swdio_out | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | 1 drives the data line, 0 releases it |
| swdio_in | input | 1 | Data line as seen at the pin |

## Verification
All sixteen combinations of port select, direction and address are run with an OK acknowledge. This shows that every header bit, including the parity bit, lands in its own slot, and that read and write data run in opposite directions. Every other acknowledge value is then played back, which separates FAULT from the protocol-error codes, followed by WAIT runs both shorter and longer than the attempt budget to locate the timeout boundary. Read parity is corrupted, and access-port requests are issued with the fault flag set, both before and after the clear. These runs show that refusal depends only on the flag and the port select.

// File: rtl/swd_xact_pkg.sv
`timescale 1ns/1ps
package swd_xact_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRNA, S_ACK, S_RDAT, S_RPAR,
    S_TRNB, S_WDAT, S_WPAR, S_TAIL
  } slot_e;

  typedef enum logic [1:0] {AFT_RETRY, AFT_WRITE, AFT_END} after_e;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_FAULT   = 3'd1;
  localparam logic [2:0] ST_TIMEOUT = 3'd2;
  localparam logic [2:0] ST_PROTO   = 3'd3;
  localparam logic [2:0] ST_PARITY  = 3'd4;
  localparam logic [2:0] ST_REFUSED = 3'd5;

  localparam int DATA_W = 32;

endpackage

// File: rtl/swd_clkgen.sv
`timescale 1ns/1ps
module swd_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          hi;
  logic          edge_now;

  assign edge_now  = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_tick = edge_now && !hi;
  assign fall_tick = edge_now && hi;
  assign swclk     = hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_req_builder.sv
`timescale 1ns/1ps
module swd_req_builder (
  input  logic       ap,
  input  logic       rnw,
  input  logic [1:0] addr,
  output logic [7:0] pkt
);
  logic par;
  assign par = ap ^ rnw ^ addr[0] ^ addr[1];
  // slot order: start, port, dir, A2, A3, parity, stop, park
  assign pkt = {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
endmodule

// File: rtl/swd_ack_decode.sv
`timescale 1ns/1ps
module swd_ack_decode (
  input  logic [2:0] ack,
  output logic       is_ok,
  output logic       is_wait,
  output logic       is_fault
);
  assign is_ok    = (ack == 3'b001);
  assign is_wait  = (ack == 3'b010);
  assign is_fault = (ack == 3'b100);
endmodule

// File: rtl/swd_xact_engine.sv
`timescale 1ns/1ps
module swd_xact_engine
  import swd_xact_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int MAX_TRIES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_ap,
  input  logic                req_rnw,
  input  logic [1:0]          req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                fault_clr,
  output logic                busy,
  output logic                done,
  output logic [2:0]          rsp_status,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                sticky_fault,
  output logic                swclk,
  output logic                swdio_out,
  output logic                swdio_oe,
  input  logic                swdio_in
);
  localparam int WCW = $clog2(MAX_TRIES + 1);
  localparam int BCW = $clog2(DATA_W);

  slot_e             state;
  after_e            after_q;
  logic [BCW-1:0]    bcnt;
  logic [WCW-1:0]    wait_cnt;
  logic              ap_q, rnw_q;
  logic [1:0]        addr_q;
  logic [DATA_W-1:0] wdata_q, data_sr;
  logic [2:0]        ack_sr, pend_st;
  logic              par_q;
  logic [7:0]        pkt;
  logic              rise_tick, fall_tick;
  logic              ack_ok, ack_wait, ack_fault;
  logic              accept, refuse, fault_set;

  assign busy      = (state != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign refuse    = accept && req_ap && sticky_fault;

  swd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .swclk(swclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  swd_req_builder u_pkt (.ap(ap_q), .rnw(rnw_q), .addr(addr_q), .pkt(pkt));

  swd_ack_decode u_ack (
    .ack(ack_sr), .is_ok(ack_ok), .is_wait(ack_wait), .is_fault(ack_fault)
  );

  assign fault_set = fall_tick && (state == S_ACK) && (bcnt == BCW'(2)) && ack_fault;

  // line drive per slot
  always_comb begin
    swdio_oe  = 1'b1;
    swdio_out = 1'b0;
    case (state)
      S_REQ:  swdio_out = pkt[bcnt[2:0]];
      S_TRNA, S_ACK, S_RDAT, S_RPAR, S_TRNB: swdio_oe = 1'b0;
      S_WDAT: swdio_out = wdata_q[bcnt];
      S_WPAR: swdio_out = ^wdata_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_fault <= 1'b0;
    else if (fault_set) sticky_fault <= 1'b1;
    else if (fault_clr) sticky_fault <= 1'b0;
  end

  // sampling on the rising serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sr  <= '0;
      data_sr <= '0;
      par_q   <= 1'b0;
    end else if (rise_tick) begin
      if (state == S_ACK)  ack_sr  <= {swdio_in, ack_sr[2:1]};
      if (state == S_RDAT) data_sr <= {swdio_in, data_sr[DATA_W-1:1]};
      if (state == S_RPAR) par_q   <= swdio_in;
    end
  end

  // slot sequencing on the falling serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      after_q    <= AFT_END;
      bcnt       <= '0;
      wait_cnt   <= '0;
      ap_q       <= 1'b0;
      rnw_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      pend_st    <= ST_OK;
      done       <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (refuse) begin
          done       <= 1'b1;
          rsp_status <= ST_REFUSED;
          rsp_rdata  <= '0;
        end else if (accept) begin
          state    <= S_REQ;
          bcnt     <= '0;
          wait_cnt <= '0;
          ap_q     <= req_ap;
          rnw_q    <= req_rnw;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
        end
      end else if (fall_tick) begin
        bcnt <= bcnt + 1'b1;
        case (state)
          S_REQ: if (bcnt == BCW'(7)) begin state <= S_TRNA; bcnt <= '0; end
          S_TRNA: begin state <= S_ACK; bcnt <= '0; end
          S_ACK: if (bcnt == BCW'(2)) begin
            bcnt  <= '0;
            state <= S_TRNB;
            if (ack_ok && rnw_q) begin
              state <= S_RDAT;
            end else if (ack_ok) begin
              after_q <= AFT_WRITE;
            end else if (ack_wait && (int'(wait_cnt) + 1 < MAX_TRIES)) begin
              after_q  <= AFT_RETRY;
              wait_cnt <= wait_cnt + 1'b1;
            end else begin
              after_q <= AFT_END;
              pend_st <= ack_wait ? ST_TIMEOUT : (ack_fault ? ST_FAULT : ST_PROTO);
            end
          end
          S_RDAT: if (bcnt == BCW'(DATA_W - 1)) begin state <= S_RPAR; bcnt <= '0; end
          S_RPAR: begin
            state   <= S_TRNB;
            bcnt    <= '0;
            after_q <= AFT_END;
            pend_st <= (par_q == ^data_sr) ? ST_OK : ST_PARITY;
          end
          S_TRNB: begin
            bcnt <= '0;
            case (after_q)
              AFT_RETRY: state <= S_REQ;
              AFT_WRITE: state <= S_WDAT;
              default: begin
                state      <= S_IDLE;
                done       <= 1'b1;
                rsp_status <= pend_st;
                rsp_rdata  <= (rnw_q && (pend_st == ST_OK || pend_st == ST_PARITY)) ? data_sr : '0;
              end
            endcase
          end
          S_WDAT: if (bcnt == BCW'(DATA_W - 1)) begin state <= S_WPAR; bcnt <= '0; end
          S_WPAR: begin state <= S_TAIL; bcnt <= '0; end
          S_TAIL: if (bcnt == BCW'(1)) begin
            state      <= S_IDLE;
            bcnt       <= '0;
            done       <= 1'b1;
            rsp_status <= ST_OK;
            rsp_rdata  <= '0;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/swd_xact_engine_chk.sv
`timescale 1ns/1ps
module swd_xact_engine_chk
  import swd_xact_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_ap,
  input logic        fault_clr,
  input logic        busy,
  input logic        done,
  input logic [2:0]  rsp_status,
  input logic [31:0] rsp_rdata,
  input logic        sticky_fault,
  input logic        swclk,
  input logic        swdio_out,
  input logic        swdio_oe,
  input slot_e       state
);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_ready)) |=> ($stable(rsp_status) && $stable(rsp_rdata)));

  p_swclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);

  p_release_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK || state == S_RDAT || state == S_RPAR) |-> !swdio_oe);

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_status == ST_FAULT) |-> (rsp_rdata == 32'd0 && sticky_fault));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_ap && sticky_fault) |=>
      (done && rsp_status == ST_REFUSED && !busy));

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_fault && !fault_clr) |=> sticky_fault);

  p_tail_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAIL) |-> (swdio_oe && !swdio_out));
endmodule

bind swd_xact_engine swd_xact_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ap(req_ap), .fault_clr(fault_clr), .busy(busy), .done(done),
  .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .sticky_fault(sticky_fault),
  .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .state(state)
);

// File: tb/swd_xact_engine_tb.sv
`timescale 1ns/1ps
module swd_xact_engine_tb;
  localparam int HALF_DIV  = 2;
  localparam int MAX_TRIES = 3;
  localparam int NS = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_ap, req_rnw, fault_clr;
  logic [1:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic busy, done, sticky_fault, swclk, swdio_out, swdio_oe, swdio_in;
  logic [2:0] rsp_status;

  swd_xact_engine #(.HALF_DIV(HALF_DIV), .MAX_TRIES(MAX_TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ap(req_ap), .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .fault_clr(fault_clr), .busy(busy), .done(done), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .sticky_fault(sticky_fault), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  int errors = 0, checks = 0;
  bit exp_oe [NS];
  bit exp_out[NS];
  bit tin    [NS];
  int nslots, idx, cyc, last_rise;
  bit wave_bad, period_bad, m_sticky;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc = cyc + 1;

  // target model: compare host slots on rising edge, drive on falling edge
  always @(posedge swclk) begin
    if (idx < NS) begin
      if (swdio_oe !== exp_oe[idx] || (exp_oe[idx] && swdio_out !== exp_out[idx])) wave_bad = 1;
    end else wave_bad = 1;
    if (idx > 0 && (cyc - last_rise) != 2 * HALF_DIV) period_bad = 1;
    last_rise = cyc;
    idx = idx + 1;
  end
  always @(negedge swclk) swdio_in <= (idx < NS) ? tin[idx] : 1'b0;

  task automatic put(input bit oe, input bit o, input bit i);
    exp_oe[nslots] = oe; exp_out[nslots] = o; tin[nslots] = i;
    nslots++;
  endtask

  task automatic xact(input bit ap, input bit rnw, input logic [1:0] addr,
                      input logic [31:0] wd, input logic [31:0] td,
                      input int nw, input logic [2:0] fack, input bit badpar);
    logic [7:0] pkt;
    logic [2:0] est;
    logic [31:0] erd;
    logic [2:0] held;
    string stag;
    bit refused;
    int att, n;
    pkt = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    nslots = 0; erd = 0;
    refused = m_sticky && ap;
    if (refused) begin
      est = 3'd5; stag = "R8";
    end else begin
      att = (nw >= MAX_TRIES) ? MAX_TRIES : nw + 1;
      for (int a = 0; a < att; a++) begin
        logic [2:0] ak;
        for (int b = 0; b < 8; b++) put(1, pkt[b], 0);
        put(0, 0, 0);
        ak = (a < nw) ? 3'b010 : fack;
        for (int b = 0; b < 3; b++) put(0, 0, ak[b]);
        if (a < att - 1) put(0, 0, 0);
      end
      if (nw >= MAX_TRIES) begin
        put(0, 0, 0); est = 3'd2; stag = "R6";
      end else if (fack == 3'b001 && rnw) begin
        for (int b = 0; b < 32; b++) put(0, 0, td[b]);
        put(0, 0, (^td) ^ badpar);
        put(0, 0, 0);
        est = badpar ? 3'd4 : 3'd0; stag = "R10"; erd = td;
      end else if (fack == 3'b001) begin
        put(0, 0, 0);
        for (int b = 0; b < 32; b++) put(1, wd[b], 0);
        put(1, ^wd, 0);
        put(1, 0, 0); put(1, 0, 0);
        est = 3'd0; stag = "R11";
      end else if (fack == 3'b100) begin
        put(0, 0, 0); est = 3'd1; stag = "R7"; m_sticky = 1;
      end else begin
        put(0, 0, 0); est = 3'd3; stag = "R5";
      end
    end
    idx = 0; wave_bad = 0; period_bad = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_ap = ap; req_rnw = rnw; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!refused) chk(req_ready == 0 && busy == 1, "R1 ready low while busy", {31'd0, req_ready}, 0);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1, "R1 done pulse", {31'd0, done}, 1);
    chk(rsp_status == est, stag, {29'd0, rsp_status}, {29'd0, est});
    chk(rsp_rdata == erd, "R12/R10 rdata", rsp_rdata, erd);
    chk(idx == nslots, "R6/R11 slot count", idx, nslots);
    chk(!wave_bad, "R2/R4/R11 line waveform", {31'd0, wave_bad}, 0);
    chk(!period_bad, "R3 slot period", {31'd0, period_bad}, 0);
    chk(sticky_fault == m_sticky, "R9 sticky flag", {31'd0, sticky_fault}, {31'd0, m_sticky});
    held = rsp_status;
    repeat (3) @(negedge clk);
    chk(rsp_status == held && !done && !swclk, "R1 result held", {29'd0, rsp_status}, {29'd0, held});
  endtask

  task automatic clear_fault();
    @(negedge clk) fault_clr = 1;
    @(negedge clk) fault_clr = 0;
    m_sticky = 0;
    chk(sticky_fault == 0, "R9 clear", {31'd0, sticky_fault}, 0);
  endtask

  initial begin
    #(750us);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc = 0; last_rise = 0; idx = 0; m_sticky = 0;
    rst_n = 0; req_valid = 0; req_ap = 0; req_rnw = 0; req_addr = 0;
    req_wdata = 0; fault_clr = 0; swdio_in = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && busy == 0 && done == 0, "R1 reset idle", {31'd0, req_ready}, 1);
    chk(swclk == 0 && swdio_oe == 1 && swdio_out == 0, "R3 reset line", {29'd0, swclk, swdio_oe, swdio_out}, 32'd2);
    chk(sticky_fault == 0, "R9 reset flag", {31'd0, sticky_fault}, 0);

    // R2 header sweep over port, direction, address with OK
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      xact(v[0], v[1], v[3:2], 32'h1234_5678 ^ (32'(i) * 32'h0101_0101),
           (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : 32'hA5C3_0F00 + 32'(i) * 32'h1111_1111,
           0, 3'b001, 0);
    end

    // R5/R7 acknowledge sweep
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) begin
        xact(0, 1, 2'd1, 0, 32'hDEAD_BEEF, 0, 3'(a), 0);
        if (a == 4) clear_fault();
      end
    end

    // R6 retry budget
    xact(0, 1, 2'd3, 0, 32'h0BAD_F00D, 1, 3'b001, 0);
    xact(1, 0, 2'd2, 32'hCAFE_0001, 0, 2, 3'b001, 0);
    xact(0, 1, 2'd0, 0, 32'h1, 3, 3'b001, 0);
    xact(1, 0, 2'd1, 32'h7, 0, 5, 3'b001, 0);

    // R10 parity error
    xact(0, 1, 2'd2, 0, 32'h8000_0001, 0, 3'b001, 1);
    xact(1, 1, 2'd0, 0, 32'h0000_0100, 0, 3'b001, 1);

    // R7/R8/R9 sticky fault behaviour
    xact(0, 0, 2'd1, 32'h5555_AAAA, 0, 0, 3'b100, 0);
    xact(1, 1, 2'd3, 0, 32'h1234, 0, 3'b001, 0);
    xact(1, 0, 2'd0, 32'hFFFF_0000, 0, 0, 3'b001, 0);
    xact(0, 1, 2'd1, 0, 32'h0000_00F0, 0, 3'b001, 0);
    xact(0, 0, 2'd0, 32'h0000_001E, 0, 0, 3'b001, 0);
    clear_fault();
    xact(1, 1, 2'd3, 0, 32'h600D_600D, 0, 3'b001, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule